// File: doc/BRIEF.md
# Clear-on-Match 8-bit Timer with Toggle Output

This block is an up-counting timer whose count returns to zero on the timer tick where it equals a programmable compare value. The compare value therefore sets the top of the count and the period. A free-running divider turns the system clock into a one-cycle tick enable. The divide ratio is chosen from a fixed set, and one select value halts the timer.

Each time the count is cleared by a match, a sticky match flag is raised. In toggle mode, the waveform output also inverts, which gives a square wave of frequency f_clk / (2·N·(1+compare)). When a tick carries the count from its all-ones value to zero, a sticky overflow flag is raised.

Software uses a small register port to program the compare value, the count and a control register, and to read them back. Writes to the compare value take effect at once, with no shadow copy. If the new value is below the running count, the counter runs on to all ones and wraps before a match can happen. Each flag has its own clear input.

Top module: `ctc_timer8`

## Requirements
- R1: After reset the count, compare value, control register, both flags and the waveform output are all 0.
- R2: On a tick where the count differs from the compare value, the count rises by one, wrapping from 0xFF to 0x00.
- R3: On a tick where the count equals the compare value, the count becomes 0 and the match flag is set, so a match recurs every 1+compare ticks.
- R4: A compare write is used from the next cycle on. When the new value is below the count, no match occurs until the count has passed 0xFF, wrapped to 0x00 and climbed back to the compare value.
- R5: The overflow flag is set on every tick that takes the count from 0xFF to 0x00, including when the compare value is 0xFF.
- R6: Control bits [2:0] select the tick rate. Value 0 stops the timer. Values 1 to 7 give one tick every 1, 8, 32, 64, 128, 256 and 1024 clock cycles.
- R7: Control bits [5:4] set the output mode. With 01 the waveform output inverts on every match, giving f_clk/2 when the compare value is 0 and the rate is 1. With any other value the output keeps its level.
- R8: A write to the count loads the written value in place of that cycle's increment, and suppresses the match, the overflow and the toggle for that cycle.
- R9: Both flags stay set until a clear input is high for a cycle. A new event in the same cycle as a clear leaves the flag set.
- R10: Register addresses are 0 for compare, 1 for count and 2 for control. The read port returns the selected register combinationally, and address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 8 | Read data for rd_addr |
| clr_match | input | 1 | Clears the match flag |
| clr_ovf | input | 1 | Clears the overflow flag |
| match_flag | output | 1 | Sticky compare-match flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| wave_out | output | 1 | Toggle waveform output |

## Verification
The assertions assume that the write, read-address and clear inputs change only between rising edges, and that they hold known values whenever reset is released. The bench drives every input on the falling edge and holds it for a whole cycle. It leaves the write strobe low except during single-cycle register writes, so the write and the tick interactions that the assertions describe are reached only through ordinary register traffic.

// File: rtl/ctc_timer_pkg.sv
package ctc_timer_pkg;

   typedef enum logic [1:0] {
      OUT_HOLD   = 2'b00,
      OUT_TOGGLE = 2'b01,
      OUT_RSV_A  = 2'b10,
      OUT_RSV_B  = 2'b11
   } out_mode_e;

   typedef enum logic [1:0] {
      REG_CMP  = 2'd0,
      REG_CNT  = 2'd1,
      REG_CTRL = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   localparam int SEL_W    = 3;
   localparam int SEL_LSB  = 0;
   localparam int MODE_LSB = 4;
   localparam int CTRL_MIN = MODE_LSB + 2;
   localparam int MAX_SHIFT = 10;

   // log2 of the divide ratio for each nonzero select value
   function automatic int unsigned rate_shift(input int unsigned s);
      case (s)
         1: return 0;
         2: return 3;
         3: return 5;
         4: return 6;
         5: return 7;
         6: return 8;
         7: return 10;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/ctc_prescale.sv
module ctc_prescale
   import ctc_timer_pkg::*;
#(
   parameter int DIV_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int NSEL = 1 << SEL_W;

   if (DIV_W < MAX_SHIFT) begin : g_bad_div
      $error("ctc_prescale: DIV_W must cover the largest divide ratio");
   end

   logic [DIV_W-1:0] div_q;
   logic [NSEL-1:0]  tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   assign tap[0] = 1'b0;
   for (genvar s = 1; s < NSEL; s++) begin : g_tap
      localparam int unsigned SH = rate_shift(s);
      if (SH == 0) begin : g_every
         assign tap[s] = 1'b1;
      end else begin : g_div
         assign tap[s] = &div_q[SH-1:0];
      end
   end

   assign tick = tap[sel];

   AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '0) |-> !tick);  // R6
   AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_W'(1)) |-> tick);  // R6
   AST_DIV8_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_W'(2) && $past(sel) == SEL_W'(2) && tick) |=> !tick);  // R6

endmodule

// File: rtl/ctc_count.sv
module ctc_count #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         cnt_wr,
   input  logic [W-1:0] cnt_wdata,
   input  logic [W-1:0] cmp,
   output logic [W-1:0] cnt,
   output logic         match_evt,
   output logic         ovf_evt
);
   logic [W-1:0] cnt_q;
   logic         at_top;
   logic         at_max;
   logic         live;

   assign at_top    = (cnt_q == cmp);
   assign at_max    = &cnt_q;
   assign live      = tick & ~cnt_wr;
   assign match_evt = live & at_top;
   assign ovf_evt   = live & at_max;
   assign cnt       = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_wr) cnt_q <= cnt_wdata;
      else if (tick)   cnt_q <= at_top ? '0 : cnt_q + 1'b1;
   end

   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && cnt != cmp) |=> (cnt == W'($past(cnt) + 1'b1)));  // R2
   AST_CLEAR_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && cnt == cmp) |=> (cnt == '0));  // R3
   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt == $past(cnt_wdata)));  // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cnt_wr) |=> $stable(cnt));  // R6

endmodule

// File: rtl/ctc_outunit.sv
module ctc_outunit
   import ctc_timer_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      match_evt,
   input  logic      ovf_evt,
   input  logic      clr_match,
   input  logic      clr_ovf,
   input  out_mode_e mode,
   output logic      match_flag,
   output logic      ovf_flag,
   output logic      wave
);
   logic do_toggle;

   assign do_toggle = match_evt & (mode == OUT_TOGGLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_flag <= 1'b0;
         ovf_flag   <= 1'b0;
         wave       <= 1'b0;
      end else begin
         if (match_evt)      match_flag <= 1'b1;
         else if (clr_match) match_flag <= 1'b0;
         if (ovf_evt)        ovf_flag   <= 1'b1;
         else if (clr_ovf)   ovf_flag   <= 1'b0;
         if (do_toggle)      wave       <= ~wave;
      end
   end

   AST_MATCH_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt |=> match_flag);  // R9
   AST_OVF_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> ovf_flag);  // R5
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (match_flag && !clr_match) |=> match_flag);  // R9
   AST_WAVE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (match_evt && mode == OUT_TOGGLE) |=> (wave != $past(wave)));  // R7
   AST_WAVE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(match_evt && mode == OUT_TOGGLE) |=> $stable(wave));  // R7

endmodule

// File: rtl/ctc_timer8.sv
module ctc_timer8
   import ctc_timer_pkg::*;
#(
   parameter int W     = 8,
   parameter int DIV_W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [1:0]   wr_addr,
   input  logic [W-1:0] wr_data,
   input  logic [1:0]   rd_addr,
   output logic [W-1:0] rd_data,
   input  logic         clr_match,
   input  logic         clr_ovf,
   output logic         match_flag,
   output logic         ovf_flag,
   output logic         wave_out
);
   if (W < CTRL_MIN) begin : g_bad_width
      $error("ctc_timer8: W too narrow for the control fields");
   end

   logic [W-1:0]     cmp_q;
   logic [SEL_W-1:0] sel_q;
   out_mode_e        mode_q;
   logic [W-1:0]     cnt;
   logic [W-1:0]     ctrl_rd;
   logic             tick;
   logic             cnt_wr;
   logic             match_evt;
   logic             ovf_evt;

   assign cnt_wr = wr_en && (wr_addr == REG_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         sel_q  <= '0;
         mode_q <= OUT_HOLD;
      end else if (wr_en) begin
         if (wr_addr == REG_CMP) cmp_q <= wr_data;
         if (wr_addr == REG_CTRL) begin
            sel_q  <= wr_data[SEL_LSB +: SEL_W];
            mode_q <= out_mode_e'(wr_data[MODE_LSB +: 2]);
         end
      end
   end

   always_comb begin
      ctrl_rd = '0;
      ctrl_rd[SEL_LSB +: SEL_W] = sel_q;
      ctrl_rd[MODE_LSB +: 2]    = mode_q;
      case (reg_sel_e'(rd_addr))
         REG_CMP:  rd_data = cmp_q;
         REG_CNT:  rd_data = cnt;
         REG_CTRL: rd_data = ctrl_rd;
         default:  rd_data = '0;
      endcase
   end

   ctc_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (sel_q),
      .tick (tick)
   );

   ctc_count #(.W(W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .cnt_wr   (cnt_wr),
      .cnt_wdata(wr_data),
      .cmp      (cmp_q),
      .cnt      (cnt),
      .match_evt(match_evt),
      .ovf_evt  (ovf_evt)
   );

   ctc_outunit u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .match_evt (match_evt),
      .ovf_evt   (ovf_evt),
      .clr_match (clr_match),
      .clr_ovf   (clr_ovf),
      .mode      (mode_q),
      .match_flag(match_flag),
      .ovf_flag  (ovf_flag),
      .wave      (wave_out)
   );

   AST_NO_MATCH_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr && !clr_match && !match_flag) |=> !match_flag);  // R8
   AST_OVF_ONLY_FROM_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> ($past(cnt) == {W{1'b1}} && cnt == '0));  // R5

endmodule

// File: tb/sim_ctc_timer8.sv
`timescale 1ns/1ps
module sim_ctc_timer8;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [1:0] rd_addr = 2'd0;
   logic [7:0] rd_data;
   logic       clr_match = 1'b0;
   logic       clr_ovf = 1'b0;
   logic       match_flag;
   logic       ovf_flag;
   logic       wave_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ctc_timer8 u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .clr_match(clr_match), .clr_ovf(clr_ovf), .match_flag(match_flag),
      .ovf_flag(ovf_flag), .wave_out(wave_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic logic [7:0] ctrl(input int sel, input int mode);
      return 8'((mode << 4) | sel);
   endfunction

   task automatic t_reset();
      logic [7:0] d;
      do_reset();
      rd(2'd0, d); chk("R1 compare", d, 0);
      rd(2'd1, d); chk("R1 count", d, 0);
      rd(2'd2, d); chk("R1 control", d, 0);
      chk("R1 flags", {match_flag, ovf_flag}, 0);
      chk("R1 wave", wave_out, 0);
      rd(2'd3, d); chk("R10 addr3 zero", d, 0);
   endtask

   task automatic t_basic();
      logic [7:0] d;
      do_reset();
      wr(2'd0, 8'd3);
      wr(2'd2, ctrl(1, 1));
      rd(2'd2, d); chk("R10 control readback", d, 8'h11);
      rd(2'd0, d); chk("R10 compare readback", d, 3);
      repeat (3) @(negedge clk);
      rd(2'd1, d); chk("R2 count reaches top", d, 3);
      chk("R3 no match yet", match_flag, 0);
      @(negedge clk);
      rd(2'd1, d); chk("R3 clear at top", d, 0);
      chk("R3 match flag", match_flag, 1);
      chk("R7 first toggle", wave_out, 1);
      repeat (4) @(negedge clk);
      chk("R7 second toggle", wave_out, 0);
      rd(2'd1, d); chk("R3 period four ticks", d, 0);
   endtask

   task automatic t_overflow();
      logic [7:0] d;
      do_reset();
      wr(2'd0, 8'hFF);
      wr(2'd1, 8'hFD);
      wr(2'd2, ctrl(1, 0));
      repeat (2) @(negedge clk);
      rd(2'd1, d); chk("R2 count at max", d, 8'hFF);
      chk("R5 no overflow yet", ovf_flag, 0);
      @(negedge clk);
      rd(2'd1, d); chk("R5 wrap to zero", d, 0);
      chk("R5 overflow at top FF", ovf_flag, 1);
      chk("R3 match at top FF", match_flag, 1);
      chk("R7 mode 00 holds wave", wave_out, 0);
   endtask

   task automatic t_miss();
      logic [7:0] d;
      do_reset();
      wr(2'd1, 8'd10);
      wr(2'd0, 8'd5);
      wr(2'd2, ctrl(1, 1));
      repeat (245) @(negedge clk);
      rd(2'd1, d); chk("R4 runs past low compare", d, 8'hFF);
      chk("R4 no match while passing", match_flag, 0);
      @(negedge clk);
      rd(2'd1, d); chk("R4 wraps", d, 0);
      chk("R5 overflow on wrap", ovf_flag, 1);
      chk("R4 still no match", match_flag, 0);
      repeat (5) @(negedge clk);
      rd(2'd1, d); chk("R4 climbs to compare", d, 5);
      @(negedge clk);
      rd(2'd1, d); chk("R4 late clear", d, 0);
      chk("R4 late match", match_flag, 1);
      chk("R7 toggle on late match", wave_out, 1);
   endtask

   task automatic t_prescale();
      int ratio [1:7] = '{1, 8, 32, 64, 128, 256, 1024};
      logic [7:0] d;
      logic [7:0] prev;
      for (int s = 1; s <= 7; s++) begin
         int n;
         do_reset();
         wr(2'd0, 8'hFF);
         wr(2'd2, ctrl(s, 0));
         rd(2'd1, prev);
         for (int i = 0; i < 2100; i++) begin
            @(negedge clk);
            rd(2'd1, d);
            if (d != prev) break;
         end
         prev = d;
         n = 0;
         for (int i = 0; i < 2100; i++) begin
            @(negedge clk);
            n++;
            rd(2'd1, d);
            if (d != prev) break;
         end
         chk($sformatf("R6 tick spacing sel %0d", s), n, ratio[s]);
      end
   endtask

   task automatic t_stop();
      logic [7:0] d;
      do_reset();
      wr(2'd1, 8'd7);
      repeat (50) @(negedge clk);
      rd(2'd1, d); chk("R6 select 0 stops", d, 7);
   endtask

   task automatic t_override();
      logic [7:0] d;
      logic w0, w1;
      do_reset();
      wr(2'd2, ctrl(1, 1));
      repeat (3) @(negedge clk);
      w0 = wave_out;
      @(negedge clk);
      w1 = wave_out;
      chk("R7 half-clock toggle", w1, !w0);
      @(negedge clk);
      w0 = wave_out;
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h40;
      @(negedge clk);
      wr_en = 1'b0;
      rd(2'd1, d); chk("R8 write loads count", d, 8'h40);
      chk("R8 no toggle on write", wave_out, w0);
      @(negedge clk);
      rd(2'd1, d); chk("R8 resumes counting", d, 8'h41);
      chk("R8 wave still held", wave_out, w0);
   endtask

   task automatic t_flags();
      do_reset();
      wr(2'd2, ctrl(1, 0));
      repeat (2) @(negedge clk);
      chk("R3 match with compare 0", match_flag, 1);
      clr_match = 1'b1;
      @(negedge clk);
      clr_match = 1'b0;
      chk("R9 set beats clear", match_flag, 1);
      wr(2'd2, ctrl(0, 0));
      repeat (5) @(negedge clk);
      chk("R9 flag sticky", match_flag, 1);
      clr_match = 1'b1;
      @(negedge clk);
      clr_match = 1'b0;
      chk("R9 clear works", match_flag, 0);
      wr(2'd0, 8'hFF);
      wr(2'd1, 8'hFF);
      wr(2'd2, ctrl(1, 0));
      wr(2'd2, ctrl(0, 0));
      chk("R5 overflow raised", ovf_flag, 1);
      repeat (20) @(negedge clk);
      chk("R9 overflow sticky", ovf_flag, 1);
      clr_ovf = 1'b1;
      @(negedge clk);
      clr_ovf = 1'b0;
      chk("R9 overflow clear", ovf_flag, 0);
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_basic();
      t_overflow();
      t_miss();
      t_prescale();
      t_stop();
      t_override();
      t_flags();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule